// File: doc/BRIEF.md
# Security-Filtered Interrupt State Register File

This block is the register front end for per-interrupt state in an interrupt controller that serves one processor. For every interrupt it holds a group bit, an enable bit, a pending bit, an active bit and a two-bit configuration field. For each software-generated interrupt it also holds an eight-bit source mask. A processor-side control bit and a banked binary point value sit beside them. Software reaches all of this through a single-cycle read/write bus. Each request carries a byte address, write data, byte enables and a secure attribute.

When the security extension is built in, every interrupt of group 0 is hidden from non-secure requests. In every per-interrupt window, that lane reads as zero and ignores writes. The binary point has a secure copy and a non-secure alias. A control bit selects whether the alias is its own register or a read-only view derived from the secure value. When the security extension is left out, every request is treated as secure.

Each request gets a response one cycle later, and the read data is registered. Unmapped or misaligned addresses never produce an error. They read as zero and ignore writes.

Top module: `sec_irq_regfile`

## Requirements
- R1: A request accepted in one cycle gives `rsp_ready` high in the next cycle and only then. A write response carries zero data, and a read response carries the addressed word.
- R2: A read of byte address 0x004 returns a read-only type word. Bits [4:0] hold NUM_IRQ/32-1, bits [7:5] hold NUM_CPU-1, bit 10 holds the security-extension flag, and all other bits are zero.
- R3: The group window at 0x080 holds one bit per interrupt, with interrupt i at bit i%32 of word i/32 (1 = group 1). Only a secure request can write it. A non-secure request reads zero and its writes are ignored.
- R4: Writing a 1 sets a bit and writing a 0 leaves it alone in each set window: enable at 0x100, pending at 0x200, active at 0x300. Writing a 1 clears a bit in each clear window: enable at 0x180, pending at 0x280, active at 0x380. Both windows of a pair read back the current bits, using the same layout as R3.
- R5: With the security extension present, a non-secure request finds every group-0 lane reading zero and ignoring writes. This applies in the enable, pending, active, configuration and source-mask windows. Group-1 lanes behave as for a secure request.
- R6: A write changes only the state held in byte lanes whose enable bit is set. The binary point and control registers use lane 0.
- R7: The configuration window at 0xC00 holds two bits per interrupt, at bits 2*(i%16)+1:2*(i%16) of word i/16. For software-generated interrupts (i < NUM_SGI), the upper bit always reads as 1.
- R8: The set-source window at 0xF20 holds the source mask of software-generated interrupt s in byte s%4 of word s/4. A write ORs the byte into the mask. A nonzero byte also sets that interrupt's pending bit. A read returns the masks.
- R9: A write to the clear-source window at 0xF10, which uses the same layout as R8, clears the mask bits that are written as 1. It drops the pending bit when no mask bits remain. Clearing pending through 0x280 for such an interrupt also empties its mask.
- R10: The processor control word at 0x800 holds the common-binary-point bit at bit 0. Only a secure request can write it or read it, and a non-secure request reads zero.
- R11: A secure request to the binary point at 0x808 reads the secure copy, and a secure write stores max(data[2:0], 0). A non-secure request with common-binary-point clear reads and writes the alias, and a write stores max(data[2:0], 1). The two copies reset to 0 and 1.
- R12: With common-binary-point set, a non-secure binary point read returns min(secure copy + 1, 7), and a non-secure binary point write is ignored.
- R13: Other addresses in the processor area 0x800-0xBFF, unmapped addresses and addresses that are not word-aligned read zero and ignore writes. They still get a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| req_secure | input | 1 | Secure attribute of the request |
| rsp_ready | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for write responses |

## Verification
The assertions take for granted that no request is presented while reset is held. This ensures that the first response after reset follows a real request. The assertions also take for granted that the security-extension parameter is set whenever they check non-secure views such as the nonzero binary point alias. The stimulus drives requests only after reset is released and holds `req_valid` low between tasks. It uses the default configuration, which has the security extension present, so the non-secure checks are live.

// File: rtl/sec_irq_regfile_pkg.sv
package sec_irq_regfile_pkg;

    typedef enum logic [3:0] {
        W_NONE, W_TYPE, W_GROUP, W_SETEN, W_CLREN, W_SETPEND, W_CLRPEND,
        W_SETACT, W_CLRACT, W_CFG, W_SGICLR, W_SGISET, W_CPUCTL, W_BPR
    } win_e;

    typedef struct packed {
        win_e       win;
        logic [4:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [11:0] a);
        dec_t d;
        d.win = W_NONE;
        d.idx = a[6:2];
        if (a[1:0] != 2'b00) begin
            d.win = W_NONE;
        end else if (a[11:10] == 2'b10) begin
            d.idx = '0;
            if (a[9:2] == 8'd0)      d.win = W_CPUCTL;
            else if (a[9:2] == 8'd2) d.win = W_BPR;
        end else if (a[11:7] == 5'h18) begin
            d.win = W_CFG;
        end else if (a[11:4] == 8'hF1) begin
            d.win = W_SGICLR;
            d.idx = {3'b000, a[3:2]};
        end else if (a[11:4] == 8'hF2) begin
            d.win = W_SGISET;
            d.idx = {3'b000, a[3:2]};
        end else if (a[11:10] == 2'b00) begin
            case (a[9:7])
                3'd0: if (a[6:2] == 5'd1) begin
                          d.win = W_TYPE;
                          d.idx = '0;
                      end
                3'd1: d.win = W_GROUP;
                3'd2: d.win = W_SETEN;
                3'd3: d.win = W_CLREN;
                3'd4: d.win = W_SETPEND;
                3'd5: d.win = W_CLRPEND;
                3'd6: d.win = W_SETACT;
                default: d.win = W_CLRACT;
            endcase
        end
        return d;
    endfunction

    function automatic logic [2:0] clamp_floor(input logic [2:0] v, input logic [2:0] lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic logic [2:0] inc_sat7(input logic [2:0] v);
        return (v == 3'd7) ? 3'd7 : v + 3'd1;
    endfunction

endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode
    import sec_irq_regfile_pkg::*;
(
    input  logic [11:0] addr,
    output dec_t        dec
);
    always_comb dec = decode_addr(addr);
endmodule

// File: rtl/rf_irq_state.sv
module rf_irq_state
    import sec_irq_regfile_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_SGI = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  win_e        win,
    input  logic [4:0]  idx,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    input  logic        sec,
    output logic [31:0] rdata
);
    localparam int SRC_W = 8 * NUM_SGI;

    logic [NUM_IRQ-1:0]   grp_q, en_q, pend_q, act_q, allow;
    logic [2*NUM_IRQ-1:0] cfg_q;
    logic [SRC_W-1:0]     src_q;

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) allow[i] = sec | grp_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            cfg_q  <= '0;
            src_q  <= '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (idx == 5'(i / 32) && be[(i % 32) / 8]) begin
                    case (win)
                        W_GROUP:   if (sec) grp_q[i] <= wdata[i % 32];
                        W_SETEN:   if (allow[i] && wdata[i % 32]) en_q[i]   <= 1'b1;
                        W_CLREN:   if (allow[i] && wdata[i % 32]) en_q[i]   <= 1'b0;
                        W_SETPEND: if (allow[i] && wdata[i % 32]) pend_q[i] <= 1'b1;
                        W_CLRPEND: if (allow[i] && wdata[i % 32]) pend_q[i] <= 1'b0;
                        W_SETACT:  if (allow[i] && wdata[i % 32]) act_q[i]  <= 1'b1;
                        W_CLRACT:  if (allow[i] && wdata[i % 32]) act_q[i]  <= 1'b0;
                        default: ;
                    endcase
                end
                if (win == W_CFG && idx == 5'(i / 16) && be[((i % 16) * 2) / 8] && allow[i])
                    cfg_q[2*i +: 2] <= wdata[2*(i % 16) +: 2];
            end
            for (int s = 0; s < NUM_SGI; s++) begin
                if (idx == 5'(s / 4) && be[s % 4] && allow[s]) begin
                    if (win == W_SGISET) begin
                        src_q[8*s +: 8] <= src_q[8*s +: 8] | wdata[8*(s % 4) +: 8];
                        if (wdata[8*(s % 4) +: 8] != 8'h00) pend_q[s] <= 1'b1;
                    end else if (win == W_SGICLR) begin
                        src_q[8*s +: 8] <= src_q[8*s +: 8] & ~wdata[8*(s % 4) +: 8];
                        if ((src_q[8*s +: 8] & ~wdata[8*(s % 4) +: 8]) == 8'h00)
                            pend_q[s] <= 1'b0;
                    end
                end
                if (win == W_CLRPEND && idx == 5'd0 && be[s / 8] && wdata[s] && allow[s])
                    src_q[8*s +: 8] <= 8'h00;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (idx == 5'(i / 32)) begin
                case (win)
                    W_GROUP:             rdata[i % 32] = sec & grp_q[i];
                    W_SETEN,   W_CLREN:  rdata[i % 32] = allow[i] & en_q[i];
                    W_SETPEND, W_CLRPEND: rdata[i % 32] = allow[i] & pend_q[i];
                    W_SETACT,  W_CLRACT: rdata[i % 32] = allow[i] & act_q[i];
                    default: ;
                endcase
            end
            if (win == W_CFG && idx == 5'(i / 16))
                rdata[2*(i % 16) +: 2] = allow[i] ?
                    {cfg_q[2*i+1] | (i < NUM_SGI), cfg_q[2*i]} : 2'b00;
        end
        for (int s = 0; s < NUM_SGI; s++) begin
            if ((win == W_SGISET || win == W_SGICLR) && idx == 5'(s / 4))
                rdata[8*(s % 4) +: 8] = allow[s] ? src_q[8*s +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/rf_cpu_if.sv
module rf_cpu_if
    import sec_irq_regfile_pkg::*;
#(
    parameter logic [2:0] MIN_BPR_S  = 3'd0,
    parameter logic [2:0] MIN_BPR_NS = 3'd1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  win_e        win,
    input  logic [2:0]  wdata,
    input  logic        be0,
    input  logic        sec,
    output logic [31:0] rdata
);
    logic       cbpr_q;
    logic [2:0] bpr_s_q, bpr_ns_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cbpr_q   <= 1'b0;
            bpr_s_q  <= MIN_BPR_S;
            bpr_ns_q <= MIN_BPR_NS;
        end else if (wr && be0) begin
            if (win == W_CPUCTL && sec) cbpr_q <= wdata[0];
            if (win == W_BPR) begin
                if (sec)          bpr_s_q  <= clamp_floor(wdata, MIN_BPR_S);
                else if (!cbpr_q) bpr_ns_q <= clamp_floor(wdata, MIN_BPR_NS);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (win == W_CPUCTL)
            rdata[0] = sec & cbpr_q;
        else if (win == W_BPR)
            rdata[2:0] = sec ? bpr_s_q : (cbpr_q ? inc_sat7(bpr_s_q) : bpr_ns_q);
    end
endmodule

// File: rtl/sec_irq_regfile.sv
module sec_irq_regfile
    import sec_irq_regfile_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_SGI = 16,
    parameter int NUM_CPU = 1,
    parameter bit SEC_EXT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_be,
    input  logic        req_secure,
    output logic        rsp_ready,
    output logic [31:0] rsp_rdata
);
    localparam logic [4:0] IRQ_WORDS_M1 = 5'(NUM_IRQ / 32 - 1);
    localparam logic [2:0] CPU_M1       = 3'(NUM_CPU - 1);
    localparam logic [31:0] TYPE_WORD   =
        {21'd0, SEC_EXT, 2'b00, CPU_M1, IRQ_WORDS_M1};

    dec_t        dec;
    logic        wr, eff_sec;
    logic [31:0] state_rd, cpu_rd, rd_word;

    assign wr      = req_valid & req_write;
    assign eff_sec = req_secure | ~SEC_EXT;

    rf_addr_decode u_dec (.addr(req_addr), .dec(dec));

    rf_irq_state #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) u_state (
        .clk(clk), .rst(rst), .wr(wr), .win(dec.win), .idx(dec.idx),
        .wdata(req_wdata), .be(req_be), .sec(eff_sec), .rdata(state_rd)
    );

    rf_cpu_if u_cpu (
        .clk(clk), .rst(rst), .wr(wr), .win(dec.win), .wdata(req_wdata[2:0]),
        .be0(req_be[0]), .sec(eff_sec), .rdata(cpu_rd)
    );

    assign rd_word = state_rd | cpu_rd | ((dec.win == W_TYPE) ? TYPE_WORD : 32'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : 32'd0;
        end
    end
endmodule

// File: rtl/sec_irq_regfile_chk.sv
module sec_irq_regfile_chk #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 1,
    parameter bit SEC_EXT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic        req_secure,
    input logic        rsp_ready,
    input logic [31:0] rsp_rdata
);
    localparam logic [31:0] TYPE_EXP =
        32'(NUM_IRQ / 32 - 1) | (32'(NUM_CPU - 1) << 5) | (32'(SEC_EXT) << 10);

    p_resp_next_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready);

    p_resp_only_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> $past(req_valid));

    p_write_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 32'd0));

    p_type_word_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 12'h004) |=> (rsp_rdata == TYPE_EXP));

    p_ns_group_raz_r3: assert property (@(posedge clk) disable iff (rst)
        (SEC_EXT && req_valid && !req_write && !req_secure && req_addr[11:7] == 5'h01)
        |=> (rsp_rdata == 32'd0));

    p_ns_bpr_floor_r11: assert property (@(posedge clk) disable iff (rst)
        (SEC_EXT && req_valid && !req_write && !req_secure && req_addr == 12'h808)
        |=> (rsp_rdata[2:0] != 3'd0 && rsp_rdata[31:3] == 29'd0));

    p_cpu_other_raz_r13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[11:10] == 2'b10 &&
         req_addr[9:2] != 8'd0 && req_addr[9:2] != 8'd2) |=> (rsp_rdata == 32'd0));
endmodule

bind sec_irq_regfile sec_irq_regfile_chk #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .SEC_EXT(SEC_EXT)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_secure(req_secure), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
);

// File: tb/sec_irq_regfile_tb_top.sv
`timescale 1ns/1ps
module sec_irq_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam bit S = 1'b1, NS = 1'b0;

    always #2.5 clk = ~clk;

    sec_irq_regfile dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_secure(req_secure), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit sec);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        req_wdata = d; req_be = be; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R1 write ready", {31'd0, rsp_ready}, 32'd1);
        check("R1 write data zero", rsp_rdata, 32'd0);
    endtask

    task automatic rd(input logic [11:0] a, input bit sec, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        req_wdata = '0; req_be = '0; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 read ready", {31'd0, rsp_ready}, 32'd1);
        d = rsp_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input bit sec,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(a, sec, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R2 type word", 12'h004, S, 32'h0000_0401);
        rd_chk("R11 reset secure bpr", 12'h808, S, 32'd0);
        rd_chk("R11 reset alias bpr", 12'h808, NS, 32'd1);
        rd_chk("R4 reset enable", 12'h100, S, 32'd0);
        @(negedge clk);
        check("R1 idle no ready", {31'd0, rsp_ready}, 32'd0);
    endtask

    task automatic t_group();
        wr(12'h080, 32'hFFFF_FFFF, 4'hF, NS);
        rd_chk("R3 ns group write ignored", 12'h080, S, 32'd0);
        wr(12'h080, 32'h0000_FF00, 4'hF, S);
        wr(12'h084, 32'hFFFF_0000, 4'hF, S);
        rd_chk("R3 group readback", 12'h080, S, 32'h0000_FF00);
        rd_chk("R3 ns group raz", 12'h080, NS, 32'd0);
    endtask

    task automatic t_enable();
        wr(12'h100, 32'h0000_0F0F, 4'hF, S);
        rd_chk("R4 set enable", 12'h100, S, 32'h0000_0F0F);
        wr(12'h180, 32'h0000_0001, 4'hF, S);
        rd_chk("R4 clear enable", 12'h180, S, 32'h0000_0F0E);
        rd_chk("R5 ns enable view", 12'h100, NS, 32'h0000_0F00);
        wr(12'h100, 32'hFFFF_FFFF, 4'hF, NS);
        rd_chk("R5 ns set only group1", 12'h100, S, 32'h0000_FF0E);
        wr(12'h180, 32'hFFFF_FFFF, 4'hF, NS);
        rd_chk("R5 ns clear only group1", 12'h100, S, 32'h0000_000E);
    endtask

    task automatic t_lanes();
        wr(12'h204, 32'hFFFF_FFFF, 4'b0100, S);
        rd_chk("R6 set pending one lane", 12'h204, S, 32'h00FF_0000);
        rd_chk("R5 ns pending group1", 12'h204, NS, 32'h00FF_0000);
        wr(12'h284, 32'hFFFF_FFFF, 4'b1000, S);
        rd_chk("R6 clear other lane no effect", 12'h204, S, 32'h00FF_0000);
        wr(12'h284, 32'hFFFF_FFFF, 4'b0100, S);
        rd_chk("R4 clear pending", 12'h284, S, 32'd0);
    endtask

    task automatic t_active();
        wr(12'h304, 32'h8000_0001, 4'hF, S);
        rd_chk("R4 set active", 12'h304, S, 32'h8000_0001);
        rd_chk("R5 ns active view", 12'h384, NS, 32'h8000_0000);
        wr(12'h384, 32'hFFFF_FFFF, 4'hF, NS);
        rd_chk("R5 ns clear active group1", 12'h304, S, 32'h0000_0001);
        wr(12'h384, 32'h0000_0001, 4'hF, S);
        rd_chk("R4 clear active", 12'h304, S, 32'd0);
    endtask

    task automatic t_cfg();
        rd_chk("R7 sgi edge bits", 12'hC00, S, 32'hAAAA_AAAA);
        wr(12'hC04, 32'h0000_0003, 4'hF, S);
        rd_chk("R7 cfg write", 12'hC04, S, 32'h0000_0003);
        wr(12'hC0C, 32'hFFFF_FFFF, 4'hF, NS);
        rd_chk("R7 ns cfg group1", 12'hC0C, NS, 32'hFFFF_FFFF);
        wr(12'hC08, 32'h5555_5555, 4'hF, NS);
        rd_chk("R5 ns cfg group0 ignored", 12'hC08, S, 32'd0);
        rd_chk("R5 ns cfg view sgi", 12'hC00, NS, 32'hAAAA_0000);
    endtask

    task automatic t_sgi();
        wr(12'hF28, 32'h0000_0500, 4'b0010, S);
        rd_chk("R8 source sets pending", 12'h200, S, 32'h0000_0200);
        rd_chk("R8 source readback", 12'hF28, S, 32'h0000_0500);
        wr(12'hF18, 32'h0000_0100, 4'b0010, S);
        rd_chk("R9 partial clear keeps pending", 12'h200, S, 32'h0000_0200);
        wr(12'hF18, 32'h0000_0400, 4'b0010, S);
        rd_chk("R9 last source drops pending", 12'h200, S, 32'd0);
        rd_chk("R9 sources empty", 12'hF28, S, 32'd0);
        wr(12'hF20, 32'h00FF_0000, 4'b0100, NS);
        rd_chk("R5 ns sgi group0 pending", 12'h200, S, 32'd0);
        rd_chk("R5 ns sgi group0 source", 12'hF20, S, 32'd0);
        wr(12'hF28, 32'h0000_0000, 4'b0100, S);
        rd_chk("R8 zero byte no pending", 12'h200, S, 32'd0);
        wr(12'hF28, 32'h0000_0300, 4'b0010, S);
        wr(12'h280, 32'h0000_0200, 4'hF, S);
        rd_chk("R9 clear pending window", 12'h200, S, 32'd0);
        rd_chk("R9 clear pending empties sources", 12'hF28, S, 32'd0);
    endtask

    task automatic t_cpuif();
        wr(12'h800, 32'd1, 4'h1, NS);
        rd_chk("R10 ns ctl write ignored", 12'h800, S, 32'd0);
        wr(12'h808, 32'd5, 4'h1, S);
        rd_chk("R11 secure bpr", 12'h808, S, 32'd5);
        rd_chk("R11 alias separate", 12'h808, NS, 32'd1);
        wr(12'h808, 32'd0, 4'h1, NS);
        rd_chk("R11 alias floor", 12'h808, NS, 32'd1);
        wr(12'h808, 32'hFFFF_FFFB, 4'h1, NS);
        rd_chk("R11 alias low bits", 12'h808, NS, 32'd3);
        wr(12'h808, 32'd2, 4'h0, S);
        rd_chk("R6 bpr lane off", 12'h808, S, 32'd5);
        wr(12'h800, 32'd1, 4'h1, S);
        rd_chk("R10 ctl secure read", 12'h800, S, 32'd1);
        rd_chk("R10 ctl ns raz", 12'h800, NS, 32'd0);
        rd_chk("R12 common view", 12'h808, NS, 32'd6);
        wr(12'h808, 32'd7, 4'h1, NS);
        wr(12'h808, 32'd7, 4'h1, S);
        rd_chk("R12 common view saturates", 12'h808, NS, 32'd7);
        wr(12'h808, 32'd5, 4'h1, S);
        wr(12'h800, 32'd0, 4'h1, S);
        rd_chk("R12 ns write ignored", 12'h808, NS, 32'd3);
    endtask

    task automatic t_misc();
        rd_chk("R13 cpu other raz", 12'h804, S, 32'd0);
        wr(12'h804, 32'hFFFF_FFFF, 4'hF, S);
        rd_chk("R13 cpu other write", 12'h804, S, 32'd0);
        rd_chk("R13 unmapped raz", 12'hE00, S, 32'd0);
        wr(12'h101, 32'hFFFF_FFFF, 4'hF, S);
        rd_chk("R13 misaligned write ignored", 12'h100, S, 32'h0000_000E);
        rd_chk("R13 misaligned read raz", 12'h101, S, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_group();
        t_enable();
        t_lanes();
        t_active();
        t_cfg();
        t_sgi();
        t_cpuif();
        t_misc();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule